// File: doc/BRIEF.md
# DMA Control, Status and Interrupt Registers

This block is the software-visible register set of an Ethernet-style DMA engine. It is reached through a plain 32-bit single-cycle write port with a combinational read path. There are four word addresses. A control register starts and stops the transmit and receive engines and requests a transmit-FIFO flush. An interrupt-enable register selects which summary classes drive the interrupt line. A status register collects sticky event flags from the datapath. A poll-demand address holds no state; writing to it nudges the transmit fetch logic.

The datapath reports events as single-cycle pulses on `dma_events`, and the block latches each one. Software clears a flag by writing a 1 to its bit. Two summary bits are derived from the pending flags: one for the abnormal class and one for the normal class. The live 3-bit process-state codes of both engines are placed in the upper part of the status word. The interrupt line is high while any summary class that is enabled has a pending flag.

Top module: `dma_csr_block`

## Requirements
- R1: After reset the control register, interrupt-enable register and every pending flag read 0, and `irq`, `tx_kick`, `tx_run`, `rx_run` and `flush_req` are 0.
- R2: A write of any value to address 3 raises `tx_kick` for exactly one cycle, starting in the cycle after the write. Address 3 always reads 0.
- R3: Control bit 13 drives `tx_run` and control bit 1 drives `rx_run`. Each is set and cleared independently by writes to address 0 and reads back at the same bit.
- R4: Writing 1 to control bit 20 sets `flush_req`, and bit 20 reads 1 until a `flush_done` pulse arrives, after which it reads 0. Writing 0 to bit 20 while a flush is pending does not cancel it.
- R5: A pulse on `dma_events[i]` sets status bit i (i = 0..10), and the bit stays set. The event positions are: 0 transmit complete, 1 transmit stopped, 2 jabber timeout, 3 underflow, 4 receive overflow, 5 receive complete, 6 receive buffer unavailable, 7 receive stopped, 8 receive watchdog, 9 early transmit, 10 fatal bus error.
- R6: A write to address 2 clears every status bit 10..0 written with 1 and leaves bits written with 0 unchanged. An event on a bit in the same cycle as its clear leaves the bit set.
- R7: Status bit 15 reads 1 exactly when any of bits 1, 2, 3, 4, 6, 7, 8, 9 or 10 is pending.
- R8: Status bit 16 reads 1 exactly when bit 0 or bit 5 is pending.
- R9: Status bits 22..20 show `tx_state` and bits 19..17 show `rx_state` live. Writes to address 2 never change them.
- R10: Interrupt-enable bit 15 enables the abnormal class and bit 16 enables the normal class. `irq` is high while an enabled summary is set. Writing 0 masks everything. `irq` falls in the cycle after the write that clears the last enabled pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 enable, 2 status, 3 poll |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dma_events | input | 11 | Event pulses from the datapath |
| tx_state | input | 3 | Live transmit process-state code |
| rx_state | input | 3 | Live receive process-state code |
| flush_done | input | 1 | Pulse when the transmit FIFO flush has finished |
| tx_run | output | 1 | Transmit engine enabled |
| rx_run | output | 1 | Receive engine enabled |
| flush_req | output | 1 | Transmit FIFO flush requested |
| tx_kick | output | 1 | One-cycle poll-demand strobe |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a datapath event latching a status flag, and a software write-one-to-clear of that same flag. The bench drives an event pulse and a status write that clears both that bit and an older pending bit on the same clock edge. It then expects the raced bit to remain set and the older bit to be gone. The flush bit is tested in a similar way, by writing 0 to it while it is pending, and the bench expects it to survive until `flush_done`.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int REG_W   = 32;
  localparam int EVT_W   = 11;
  localparam int STATE_W = 3;

  // control bit positions
  localparam int CTL_RX_BIT    = 1;
  localparam int CTL_TX_BIT    = 13;
  localparam int CTL_FLUSH_BIT = 20;

  // status / enable summary positions
  localparam int SUM_ABN_BIT = 15;
  localparam int SUM_NRM_BIT = 16;
  localparam int RX_ST_LSB   = 17;
  localparam int TX_ST_LSB   = 20;

  // which event flags belong to the normal class (tx done, rx done)
  localparam logic [EVT_W-1:0] NRM_EVT_MASK = EVT_W'(11'h021);
  localparam logic [EVT_W-1:0] ABN_EVT_MASK = EVT_W'(11'h7DE);

  localparam logic [REG_W-1:0] IE_DEFAULT =
    (REG_W'(1) << SUM_ABN_BIT) | (REG_W'(1) << SUM_NRM_BIT);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_IE   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_POLL = 2'd3
  } reg_sel_e;

  function automatic logic abn_summary(input logic [EVT_W-1:0] pend);
    return |(pend & ABN_EVT_MASK);
  endfunction

  function automatic logic nrm_summary(input logic [EVT_W-1:0] pend);
    return |(pend & NRM_EVT_MASK);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic [EVT_W-1:0]   pend,
    input logic [STATE_W-1:0] txs,
    input logic [STATE_W-1:0] rxs
  );
    logic [REG_W-1:0] w;
    w = '0;
    w[EVT_W-1:0] = pend;
    w[SUM_ABN_BIT] = abn_summary(pend);
    w[SUM_NRM_BIT] = nrm_summary(pend);
    w[RX_ST_LSB +: STATE_W] = rxs;
    w[TX_ST_LSB +: STATE_W] = txs;
    return w;
  endfunction

endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_ie,
  input  logic wr_poll,
  input  logic set_tx_run,
  input  logic set_rx_run,
  input  logic set_flush,
  input  logic set_ie_abn,
  input  logic set_ie_nrm,
  input  logic flush_done,
  output logic tx_run,
  output logic rx_run,
  output logic flush_pend,
  output logic ie_abn,
  output logic ie_nrm,
  output logic tx_kick
);

  logic flush_nxt;

  // set by software, cleared only by completion; a fresh set wins
  assign flush_nxt = (wr_ctrl && set_flush) || (flush_pend && !flush_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_run     <= 1'b0;
      rx_run     <= 1'b0;
      flush_pend <= 1'b0;
      ie_abn     <= 1'b0;
      ie_nrm     <= 1'b0;
      tx_kick    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tx_run <= set_tx_run;
        rx_run <= set_rx_run;
      end
      if (wr_ie) begin
        ie_abn <= set_ie_abn;
        ie_nrm <= set_ie_nrm;
      end
      flush_pend <= flush_nxt;
      tx_kick    <= wr_poll;
    end
  end

  p_kick_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_poll |=> tx_kick);
  p_kick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_poll |=> !tx_kick);
  p_flush_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && !flush_done) |=> flush_pend);
  p_flush_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_done && !(wr_ctrl && set_flush)) |=> !flush_pend);

endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status #(
  parameter int EVT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] ev_in,
  input  logic [EVT_W-1:0] clr_mask,
  output logic [EVT_W-1:0] pend
);

  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    logic flag_nxt;
    // an arriving event outranks a simultaneous clear
    assign flag_nxt = ev_in[i] || (pend[i] && !clr_mask[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= flag_nxt;
    end

    p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_in[i] |=> pend[i]);
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !ev_in[i]) |=> !pend[i]);
    p_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_mask[i] && !ev_in[i]) |=> $stable(pend[i]));
  end

endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [EVT_W-1:0]   dma_events,
  input  logic [STATE_W-1:0] tx_state,
  input  logic [STATE_W-1:0] rx_state,
  input  logic               flush_done,
  output logic               tx_run,
  output logic               rx_run,
  output logic               flush_req,
  output logic               tx_kick,
  output logic               irq
);

  reg_sel_e         sel;
  logic             wr_ctrl, wr_ie, wr_stat, wr_poll;
  logic             ie_abn, ie_nrm;
  logic [EVT_W-1:0] clr_mask;
  logic [EVT_W-1:0] pend;
  logic             sum_abn, sum_nrm;
  logic [REG_W-1:0] ctrl_word, ie_word, stat_word;
  logic             unused_wdata;

  assign sel     = reg_sel_e'(bus_addr[1:0]);
  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_ie   = bus_wr && (sel == SEL_IE);
  assign wr_stat = bus_wr && (sel == SEL_STAT);
  assign wr_poll = bus_wr && (sel == SEL_POLL);

  assign clr_mask     = wr_stat ? bus_wdata[EVT_W-1:0] : '0;
  assign unused_wdata = ^bus_wdata;

  dma_csr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_ie      (wr_ie),
    .wr_poll    (wr_poll),
    .set_tx_run (bus_wdata[CTL_TX_BIT]),
    .set_rx_run (bus_wdata[CTL_RX_BIT]),
    .set_flush  (bus_wdata[CTL_FLUSH_BIT]),
    .set_ie_abn (bus_wdata[SUM_ABN_BIT]),
    .set_ie_nrm (bus_wdata[SUM_NRM_BIT]),
    .flush_done (flush_done),
    .tx_run     (tx_run),
    .rx_run     (rx_run),
    .flush_pend (flush_req),
    .ie_abn     (ie_abn),
    .ie_nrm     (ie_nrm),
    .tx_kick    (tx_kick)
  );

  dma_csr_status #(.EVT_W(EVT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_in    (dma_events),
    .clr_mask (clr_mask),
    .pend     (pend)
  );

  assign sum_abn = abn_summary(pend);
  assign sum_nrm = nrm_summary(pend);
  assign irq     = (sum_abn && ie_abn) || (sum_nrm && ie_nrm);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_TX_BIT]    = tx_run;
    ctrl_word[CTL_RX_BIT]    = rx_run;
    ctrl_word[CTL_FLUSH_BIT] = flush_req;
    ie_word = '0;
    ie_word[SUM_ABN_BIT] = ie_abn;
    ie_word[SUM_NRM_BIT] = ie_nrm;
    stat_word = pack_status(pend, tx_state, rx_state);
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = ctrl_word;
      SEL_IE:   bus_rdata = ie_word;
      SEL_STAT: bus_rdata = stat_word;
      default:  bus_rdata = '0;
    endcase
  end

  // irq can only rise after a flag is latched or an enable is written
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(dma_events) != '0) || $past(wr_ie));
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ie && !bus_wdata[SUM_ABN_BIT] && !bus_wdata[SUM_NRM_BIT]) |=> !irq);

endmodule

// File: tb/dma_csr_block_bench.sv
module dma_csr_block_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] dma_events = '0;
  logic [2:0]  tx_state = 3'd0;
  logic [2:0]  rx_state = 3'd0;
  logic        flush_done = 1'b0;
  logic        tx_run, rx_run, flush_req, tx_kick, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_csr_block u_dma_csr_block (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_events(dma_events),
    .tx_state(tx_state), .rx_state(rx_state), .flush_done(flush_done),
    .tx_run(tx_run), .rx_run(rx_run), .flush_req(flush_req),
    .tx_kick(tx_kick), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_ev(input logic [10:0] m);
    @(negedge clk);
    dma_events = m;
    @(negedge clk);
    dma_events = '0;
  endtask

  // expected status word, built bit by bit from the requirement text
  function automatic logic [31:0] exp_stat(input logic [10:0] p, input logic [2:0] t, input logic [2:0] r);
    logic [31:0] w;
    w = {9'd0, t, r, 17'd0};
    w[10:0] = p;
    w[15] = p[1] | p[2] | p[3] | p[4] | p[6] | p[7] | p[8] | p[9] | p[10];
    w[16] = p[0] | p[5];
    return w;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(2'd0, d); check("R1 ctrl", d, 32'h0);
    rd_reg(2'd1, d); check("R1 ie", d, 32'h0);
    rd_reg(2'd2, d); check("R1 status", d, 32'h0);
    check("R1 outputs", {27'd0, irq, tx_kick, tx_run, rx_run, flush_req}, 32'h0);
  endtask

  task automatic t_poll();
    logic [31:0] d;
    wr_reg(2'd3, 32'hDEAD_BEEF);
    check("R2 kick high", {31'd0, tx_kick}, 32'h1);
    @(negedge clk);
    check("R2 kick one cycle", {31'd0, tx_kick}, 32'h0);
    wr_reg(2'd3, 32'h0);
    check("R2 kick on zero data", {31'd0, tx_kick}, 32'h1);
    rd_reg(2'd3, d); check("R2 poll reads zero", d, 32'h0);
  endtask

  task automatic t_run_bits();
    logic [31:0] d;
    wr_reg(2'd0, 32'h0000_2000);
    check("R3 tx only", {30'd0, tx_run, rx_run}, 32'h2);
    rd_reg(2'd0, d); check("R3 read tx", d, 32'h0000_2000);
    wr_reg(2'd0, 32'h0000_0002);
    check("R3 rx only", {30'd0, tx_run, rx_run}, 32'h1);
    wr_reg(2'd0, 32'h0000_2002);
    rd_reg(2'd0, d); check("R3 both", d, 32'h0000_2002);
    wr_reg(2'd0, 32'h0);
    check("R3 stop", {30'd0, tx_run, rx_run}, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    wr_reg(2'd0, 32'h0010_0000);
    check("R4 flush set", {31'd0, flush_req}, 32'h1);
    wr_reg(2'd0, 32'h0);
    rd_reg(2'd0, d); check("R4 zero write keeps flush", d, 32'h0010_0000);
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
    rd_reg(2'd0, d); check("R4 flush self-clear", d, 32'h0);
    check("R4 flush_req low", {31'd0, flush_req}, 32'h0);
  endtask

  task automatic t_events_and_w1c();
    logic [31:0] d;
    pulse_ev(11'h001);
    rd_reg(2'd2, d); check("R5 R8 tx done", d, exp_stat(11'h001, 3'd0, 3'd0));
    @(negedge clk);
    rd_reg(2'd2, d); check("R5 sticky", d, exp_stat(11'h001, 3'd0, 3'd0));
    pulse_ev(11'h400);
    rd_reg(2'd2, d); check("R5 R7 fatal bus", d, exp_stat(11'h401, 3'd0, 3'd0));
    pulse_ev(11'h020);
    wr_reg(2'd2, 32'h0000_0001);
    rd_reg(2'd2, d); check("R6 R8 clear one normal", d, exp_stat(11'h420, 3'd0, 3'd0));
    wr_reg(2'd2, 32'h0000_0000);
    rd_reg(2'd2, d); check("R6 zero write no effect", d, exp_stat(11'h420, 3'd0, 3'd0));
    wr_reg(2'd2, 32'h0000_0420);
    rd_reg(2'd2, d); check("R6 R7 R8 all clear", d, 32'h0);
    pulse_ev(11'h008);
    rd_reg(2'd2, d); check("R7 underflow only", d, exp_stat(11'h008, 3'd0, 3'd0));
    wr_reg(2'd2, 32'h0001_FFFF);
    rd_reg(2'd2, d); check("R6 wide clear", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse_ev(11'h080);
    @(negedge clk);
    dma_events = 11'h010;
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h0000_0090;
    @(negedge clk);
    dma_events = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd_reg(2'd2, d); check("R6 event beats clear", d, exp_stat(11'h010, 3'd0, 3'd0));
    wr_reg(2'd2, 32'h0000_0010);
    rd_reg(2'd2, d); check("R6 cleared after race", d, 32'h0);
  endtask

  task automatic t_state();
    logic [31:0] d;
    tx_state = 3'd6; rx_state = 3'd4;
    rd_reg(2'd2, d); check("R9 live codes", d, exp_stat(11'h0, 3'd6, 3'd4));
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, d); check("R9 write keeps codes", d, exp_stat(11'h0, 3'd6, 3'd4));
    tx_state = 3'd7; rx_state = 3'd5;
    rd_reg(2'd2, d); check("R9 codes follow", d, exp_stat(11'h0, 3'd7, 3'd5));
    tx_state = 3'd0; rx_state = 3'd0;
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr_reg(2'd1, 32'h0000_8000);
    rd_reg(2'd1, d); check("R10 ie readback", d, 32'h0000_8000);
    pulse_ev(11'h001);
    check("R10 normal masked", {31'd0, irq}, 32'h0);
    pulse_ev(11'h010);
    check("R10 abnormal raises", {31'd0, irq}, 32'h1);
    wr_reg(2'd2, 32'h0000_0010);
    check("R10 drops after clear", {31'd0, irq}, 32'h0);
    wr_reg(2'd1, 32'h0001_8000);
    check("R10 normal enabled", {31'd0, irq}, 32'h1);
    wr_reg(2'd1, 32'h0);
    check("R10 zero masks", {31'd0, irq}, 32'h0);
    wr_reg(2'd2, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_run_bits();
    t_flush();
    t_events_and_w1c();
    t_race();
    t_state();
    t_irq();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule